// File: doc/BRIEF.md
# Level-Priority Interrupt Controller

This block collects interrupt requests from a fixed set of vector slots and hands one of them at a time to the processor. Each slot has a 3-bit level that software programs through a simple write/read register bus.

A slot is pending when its peripheral raises a cause flag while that cause is enabled. One slot gathers several causes into a single request. Of the pending slots, the one with the highest nonzero level wins. When levels are equal, the lowest vector number wins.

The winner is presented as a vector number, a level and a vector-table address, together with a request strobe. The address is the programmable table base plus four times the vector number. A single global-enable input stands for the processor's interrupt mask. The presented values are held until the processor pulses the acknowledge input.

The control is a two-state machine:
- `ST_IDLE` arbitrates every cycle. Transition *grant*: when a winner exists and the global enable is high, the winner's vector, level and address are latched and the machine moves to `ST_PRESENT`.
- `ST_PRESENT` drives the request strobe and holds every presented value. Transition *release*: on acknowledge it returns to `ST_IDLE`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request strobe is 0, every slot level reads 0 and the table base reads 0x0000_8000.
- R2: A bus write to address n (n < 32) stores wdata[2:0] as the level of slot n. A read of that address returns the level in bits [2:0], with zeros above.
- R3: Bus address 32 holds the table base. Bits [7:0] of the base always read 0, whatever was written.
- R4: A slot is pending only while its flag and its enable are both 1. If the enable is set while the flag is already 1, the request appears.
- R5: Slot 21 has five causes (group flag/enable bits 0 to 4). Each cause counts only when its own flag and enable are both 1, and the causes are ORed into the request of slot 21.
- R6: A slot whose level is 0 never wins.
- R7: Among pending slots, the highest level wins.
- R8: Among pending slots of equal level, the lowest vector number wins.
- R9: Slots 24 to 31 are never reported, whatever their inputs and levels.
- R10: The presented address equals the table base plus 4 times the presented vector number.
- R11: While the global enable is 0 the strobe does not rise. The pending request is kept, and it is presented one cycle after the enable goes to 1.
- R12: While the strobe is high, vector, level and address stay stable until acknowledge. The clock edge that samples acknowledge drops the strobe, and arbitration resumes on the next edge.
- R13: A qualifying request raises the strobe at the first clock edge after the inputs become valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_flag | input | 32 | Per-slot peripheral cause flag |
| slot_en | input | 32 | Per-slot peripheral enable |
| grp_flag | input | 5 | Cause flags of the shared slot 21 |
| grp_en | input | 5 | Cause enables of the shared slot 21 |
| gie | input | 1 | Global interrupt enable from the CPU |
| ack | input | 1 | Acknowledge pulse from the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (0..31 levels, 32 table base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Request strobe to the CPU |
| irq_vec | output | 5 | Presented vector number |
| irq_lvl | output | 3 | Presented level |
| irq_addr | output | 32 | Presented vector-table address |

## Verification
A corrupt level register shows up on the bus at once on readback, and at the ports at the next grant as the wrong winner or level. A fault in the state machine shows up within one cycle of acknowledge, either as a strobe that stays high or as presented values that move while the strobe is held. An error in the base or the address arithmetic shows in the first presented address. Reserved-slot or level-0 leakage shows up one edge after the offending input as a strobe that should not be there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } irqc_state_e;
endpackage

// File: rtl/irqc_level_regs.sv
module irqc_level_regs #(
    parameter int          NUM_SLOTS  = 32,
    parameter int          LVL_W      = 3,
    parameter int          DATA_W     = 32,
    parameter int          BUS_AW     = 6,
    parameter int          ALIGN      = 8,
    parameter logic [31:0] RESET_BASE = 32'h0000_8000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [BUS_AW-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_SLOTS*LVL_W-1:0] lvl_flat,
    output logic [DATA_W-1:0]          tbl_base
);
    localparam int                VEC_W    = $clog2(NUM_SLOTS);
    localparam logic [BUS_AW-1:0] BASE_SEL = BUS_AW'(NUM_SLOTS);

    logic [LVL_W-1:0]        lvl_q [NUM_SLOTS];
    logic [DATA_W-ALIGN-1:0] base_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q[g] <= '0;
            else if (reg_wr && reg_addr == BUS_AW'(g))
                lvl_q[g] <= reg_wdata[LVL_W-1:0];
        end
        assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= RESET_BASE[DATA_W-1:ALIGN];
        else if (reg_wr && reg_addr == BASE_SEL)
            base_q <= reg_wdata[DATA_W-1:ALIGN];
    end

    assign tbl_base = {base_q, {ALIGN{1'b0}}};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < BASE_SEL)
            reg_rdata[LVL_W-1:0] = lvl_q[reg_addr[VEC_W-1:0]];
        else if (reg_addr == BASE_SEL)
            reg_rdata = tbl_base;
    end

    // R3: the base stays aligned after any write
    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_base[ALIGN-1:0] == '0);
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_VALID = 24,
    parameter int LVL_W     = 3,
    parameter int GRP_N     = 5,
    parameter int GRP_SLOT  = 21
) (
    input  logic [NUM_SLOTS-1:0]       slot_flag,
    input  logic [NUM_SLOTS-1:0]       slot_en,
    input  logic [GRP_N-1:0]           grp_flag,
    input  logic [GRP_N-1:0]           grp_en,
    input  logic [NUM_SLOTS*LVL_W-1:0] lvl_flat,
    output logic [NUM_SLOTS-1:0]       pend
);
    logic grp_hit;
    assign grp_hit = |(grp_flag & grp_en);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g >= NUM_VALID) begin : g_rsvd
            assign pend[g] = 1'b0;
        end else begin : g_live
            logic raw;
            if (g == GRP_SLOT) begin : g_grp
                assign raw = (slot_flag[g] & slot_en[g]) | grp_hit;
            end else begin : g_one
                assign raw = slot_flag[g] & slot_en[g];
            end
            assign pend[g] = raw & (|lvl_flat[g*LVL_W +: LVL_W]);
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int LVL_W     = 3,
    localparam int VEC_W    = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       pend,
    input  logic [NUM_SLOTS*LVL_W-1:0] lvl_flat,
    output logic                       win_valid,
    output logic [VEC_W-1:0]           win_vec,
    output logic [LVL_W-1:0]           win_lvl
);
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            // strict compare keeps the lower index on equal level
            if (pend[i] && lvl_flat[i*LVL_W +: LVL_W] > win_lvl) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(i);
                win_lvl   = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    // R7: the chosen slot is actually pending
    a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[win_vec]);
    // R6: any pending slot produces a winner of nonzero level
    a_r6_pending_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (win_valid && win_lvl != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int          NUM_SLOTS  = 32,
    parameter int          NUM_VALID  = 24,
    parameter int          LVL_W      = 3,
    parameter int          GRP_N      = 5,
    parameter int          GRP_SLOT   = 21,
    parameter int          DATA_W     = 32,
    parameter int          BUS_AW     = 6,
    parameter logic [31:0] RESET_BASE = 32'h0000_8000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS-1:0]      slot_flag,
    input  logic [NUM_SLOTS-1:0]      slot_en,
    input  logic [GRP_N-1:0]          grp_flag,
    input  logic [GRP_N-1:0]          grp_en,
    input  logic                      gie,
    input  logic                      ack,
    input  logic                      reg_wr,
    input  logic [BUS_AW-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      irq_req,
    output logic [$clog2(NUM_SLOTS)-1:0] irq_vec,
    output logic [LVL_W-1:0]          irq_lvl,
    output logic [DATA_W-1:0]         irq_addr
);
    import irqc_pkg::*;

    localparam int VEC_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS*LVL_W-1:0] lvl_flat;
    logic [DATA_W-1:0]          tbl_base;
    logic [NUM_SLOTS-1:0]       pend;
    logic                       win_valid;
    logic [VEC_W-1:0]           win_vec;
    logic [LVL_W-1:0]           win_lvl;

    irqc_state_e state_q, state_d;

    irqc_level_regs #(
        .NUM_SLOTS (NUM_SLOTS), .LVL_W(LVL_W), .DATA_W(DATA_W),
        .BUS_AW    (BUS_AW),    .ALIGN(8),     .RESET_BASE(RESET_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lvl_flat(lvl_flat), .tbl_base(tbl_base)
    );

    irqc_pend #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_VALID(NUM_VALID), .LVL_W(LVL_W),
        .GRP_N    (GRP_N),     .GRP_SLOT (GRP_SLOT)
    ) u_pend (
        .slot_flag(slot_flag), .slot_en(slot_en), .grp_flag(grp_flag),
        .grp_en(grp_en), .lvl_flat(lvl_flat), .pend(pend)
    );

    irqc_pick #(.NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(pend), .lvl_flat(lvl_flat),
        .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (win_valid && gie) state_d = ST_PRESENT; // grant
            ST_PRESENT: if (ack)              state_d = ST_IDLE;    // release
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // presented values, latched on grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_vec  <= '0;
            irq_lvl  <= '0;
            irq_addr <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_PRESENT) begin
            irq_vec  <= win_vec;
            irq_lvl  <= win_lvl;
            irq_addr <= tbl_base + (DATA_W'(win_vec) << 2);
        end
    end

    assign irq_req = (state_q == ST_PRESENT);

    // R9: reserved vectors are never shown
    a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (32'(irq_vec) < NUM_VALID));
    // R6: a presented level is never zero
    a_r6_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lvl != '0);
    // R10: address low part follows the vector
    a_r10_addr_vec: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_addr[VEC_W+1:2] == irq_vec && irq_addr[1:0] == 2'b00));
    // R11: strobe rises only with global enable
    a_r11_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie));
    // R12: presented values hold until acknowledge
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl) && $stable(irq_addr)));
    // R12: acknowledge drops the strobe
    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] slot_flag = '0, slot_en = '0;
    logic [4:0]  grp_flag = '0, grp_en = '0;
    logic        gie = 1'b1, ack = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_req;
    logic [4:0]  irq_vec;
    logic [2:0]  irq_lvl;
    logic [31:0] irq_addr;

    int n_chk = 0, n_err = 0;
    logic [31:0] base = 32'h0000_8000;

    always #2.5 clk = ~clk;   // 200 MHz

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_flag(slot_flag), .slot_en(slot_en),
        .grp_flag(grp_flag), .grp_en(grp_en), .gie(gie), .ack(ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_lvl(irq_lvl), .irq_addr(irq_addr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // flags and enables already driven at a negedge: one edge, then sample
    task automatic step; @(negedge clk); endtask

    task automatic ack_clear;
        ack = 1'b1; slot_flag = '0; slot_en = '0; grp_flag = '0; grp_en = '0;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic expect_win(string tag, logic [4:0] v, logic [2:0] l);
        check({tag, " req"},  32'(irq_req), 32'd1);
        check({tag, " vec"},  32'(irq_vec), 32'(v));
        check({tag, " lvl"},  32'(irq_lvl), 32'(l));
        check({tag, " addr"}, irq_addr, base + 32'(v) * 4);
    endtask

    // {flags, enables, exp_req, exp_vec, exp_lvl}
    localparam int NV = 10;
    localparam logic [72:0] TV [NV] = '{
        {32'h0000_0008, 32'h0000_0008, 1'b1, 5'd3,  3'd2},  // R7 single
        {32'h0000_0028, 32'h0000_0028, 1'b1, 5'd5,  3'd5},  // R7 higher level
        {32'h0000_00A0, 32'h0000_00A0, 1'b1, 5'd5,  3'd5},  // R8 tie -> lower
        {32'h0000_04A8, 32'h0000_04A8, 1'b1, 5'd10, 3'd7},  // R7 top level
        {32'h0000_1000, 32'h0000_1000, 1'b0, 5'd0,  3'd0},  // R6 level 0
        {32'h0200_0000, 32'h0200_0000, 1'b0, 5'd0,  3'd0},  // R9 reserved
        {32'h0200_0008, 32'h0200_0008, 1'b1, 5'd3,  3'd2},  // R9 reserved loses
        {32'h0000_0008, 32'h0000_0000, 1'b0, 5'd0,  3'd0},  // R4 no enable
        {32'h0000_0009, 32'h0000_0009, 1'b1, 5'd3,  3'd2},  // R7 vs slot 0
        {32'h4000_0001, 32'h4000_0001, 1'b1, 5'd0,  3'd1}   // R9 slot 30 lvl7
    };

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req", 32'(irq_req), 0);
        reg_addr = 6'd3;  #1 check("R1 level", reg_rdata, 0);
        reg_addr = 6'd32; #1 check("R1 base", reg_rdata, 32'h0000_8000);

        // R2 level programming
        wr(6'd0, 32'hFFFF_FFF9); wr(6'd3, 2); wr(6'd5, 5); wr(6'd7, 5);
        wr(6'd10, 7); wr(6'd12, 0); wr(6'd21, 4); wr(6'd25, 7); wr(6'd30, 7);
        reg_addr = 6'd0;  #1 check("R2 readback slot0", reg_rdata, 32'd1);
        reg_addr = 6'd10; #1 check("R2 readback slot10", reg_rdata, 32'd7);

        // table of vectors, R13: sampled one edge after inputs
        for (int k = 0; k < NV; k++) begin
            slot_flag = TV[k][72:41]; slot_en = TV[k][40:9];
            step();
            if (TV[k][8]) expect_win($sformatf("R13 vec%0d", k), TV[k][7:3], TV[k][2:0]);
            else          check($sformatf("R6/R9/R4 vec%0d no req", k), 32'(irq_req), 0);
            ack_clear();
        end

        // R3 + R10 base write, low byte discarded
        wr(6'd32, 32'h0001_23FF);
        reg_addr = 6'd32; #1 check("R3 base read", reg_rdata, 32'h0001_2300);
        base = 32'h0001_2300;
        slot_flag = 32'h8; slot_en = 32'h8; step();
        expect_win("R10 new base", 5'd3, 3'd2);
        ack_clear();

        // R5 each shared cause alone
        for (int c = 0; c < 5; c++) begin
            grp_flag = 5'(1 << c); grp_en = 5'(1 << c); step();
            expect_win($sformatf("R5 cause%0d", c), 5'd21, 3'd4);
            ack_clear();
        end
        grp_flag = 5'h1F; grp_en = 5'h00; step();
        check("R5 flags without enables", 32'(irq_req), 0);
        grp_flag = 5'h01; grp_en = 5'h02; step();
        check("R5 mismatched cause", 32'(irq_req), 0);
        ack_clear();

        // R4 enable set after flag
        slot_flag = 32'h8; step(); step();
        check("R4 flag only", 32'(irq_req), 0);
        slot_en = 32'h8; step();
        expect_win("R4 late enable", 5'd3, 3'd2);
        ack_clear();

        // R11 global enable low keeps pending
        gie = 1'b0; slot_flag = 32'h20; slot_en = 32'h20;
        step(); step(); step();
        check("R11 masked", 32'(irq_req), 0);
        gie = 1'b1; step();
        expect_win("R11 unmasked", 5'd5, 3'd5);
        ack_clear();

        // R12 hold while a higher one arrives, then release
        slot_flag = 32'h8; slot_en = 32'h8; step();
        expect_win("R12 first", 5'd3, 3'd2);
        slot_flag = 32'h408; slot_en = 32'h408; step(); step();
        expect_win("R12 held", 5'd3, 3'd2);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        check("R12 dropped after ack", 32'(irq_req), 0);
        step();
        expect_win("R12 rearbitrated", 5'd10, 3'd7);
        ack_clear();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule